// File: doc/BRIEF.md
# ARINC 429 Receive Bit Decoder

This block recovers 32-bit ARINC 429 words from a receive line that has already been reduced to two synchronous comparator flags, one for a positive ("one") level and one for a negative ("zero") level. It runs from a single master clock, nominally 1 MHz. A speed select sets the sampling rate to either the master clock or the master clock divided by eight, which gives about ten samples per bit at the high or the low bus rate.

Every sample is qualified before it is used. A level counts only after three equal samples in a row. Each pulse must go back to null before the next bit begins. The distance between two bit starts must lie in a fixed window. A quiet gap must be seen before a new word may begin. If any of these rules fails, the partial word is discarded and the block waits for a new gap. A word that passes all checks comes out with its last bit replaced by a parity-error flag.

Finished words leave on a valid/ready stream port. `out_valid` stays high with `out_data` stable until a cycle in which `out_ready` is also high. The receiver cannot pause the bus, so a word that completes while an earlier one is still held replaces it. Back-pressure therefore loses older words. It never stalls reception.

Top module: `a429_rx_decoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0 and `out_data` is 0. After reset the decoder first needs a full word gap before it accepts a word.
- R2: With `speed_slow`=0 one line sample is taken every clock. With `speed_slow`=1 one sample is taken every 8 clocks, so a word timed for fast sampling is rejected in slow mode.
- R3: Line encoding per sample: `line_one`=1,`line_zero`=0 is a one bit; 0,1 is a zero bit; 0,0 is null. The first bit received (ARINC bit 1) appears at `out_data[0]`, and ARINC bit n appears at `out_data[n-1]` for n = 1..31.
- R4: `out_data[31]` is 0 when the 32 received bits hold an odd number of ones and 1 when they hold an even number.
- R5: A one or zero level is accepted only after 3 consecutive equal samples. A bit pulse of 2 samples is not a bit, and the word holding it is dropped.
- R6: Every accepted pulse must be followed by a qualified null (3 null samples) before the next pulse. A pulse that runs straight into the next bit drops the word.
- R7: The start of each bit must come 8 to 12 samples (inclusive) after the start of the previous bit. A bit period of 6, 7, 13 or 14 samples drops the word.
- R8: After a word, and after any rejection, the line is checked every 10 samples. Three null checks in a row are needed before a new word may start, and a non-null check restarts the count. A word that starts 10 samples after the previous word's last bit slot is dropped.
- R9: A sample with both `line_one` and `line_zero` high is illegal and drops the partial word.
- R10: `out_valid` rises one word at a time. It stays high with `out_data` unchanged while `out_ready` is low, unless a newer word replaces the held one. It falls on the clock after a cycle with `out_valid` and `out_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 1 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_slow | input | 1 | 0: sample every clock; 1: sample every 8 clocks |
| line_one | input | 1 | Synchronous flag for a positive line level |
| line_zero | input | 1 | Synchronous flag for a negative line level |
| out_valid | output | 1 | A decoded word is held on `out_data` |
| out_ready | input | 1 | Consumer accepts the held word |
| out_data | output | 32 | Decoded word; bit 31 is the parity-error flag |

## Verification
A fault in the qualification history or in the spacing counter shows up as a missing word or as an extra word. The bench sees this at the stream port within one word time plus the rejection gap, which is under about 70 samples after the last bit. A fault in bit assembly or parity shows up as a wrong `out_data` on the very next accepted word. A stuck gap counter shows up either as no words at all or as the short-gap word being accepted. Sweeping the bit period across the whole window, with walking-bit data, exposes both the off-by-one cases and the lane errors.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_W     = 32;
  localparam int QUAL_LEN   = 3;
  localparam int BIT_MIN    = 8;
  localparam int BIT_MAX    = 12;
  localparam int GAP_PERIOD = 10;
  localparam int GAP_NULLS  = 3;
  localparam int FAST_DIV   = 1;
  localparam int SLOW_DIV   = 8;

  typedef enum logic [1:0] {
    ST_GAP,
    ST_IDLE,
    ST_PULSE,
    ST_NULLS
  } rx_state_e;
endpackage

// File: rtl/a429_sample_tick.sv
module a429_sample_tick #(
  parameter int FAST_DIV = a429_rx_pkg::FAST_DIV,
  parameter int SLOW_DIV = a429_rx_pkg::SLOW_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_slow,
  output logic tick
);
  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= speed_slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/a429_level_qual.sv
module a429_level_qual #(
  parameter int QUAL_LEN = a429_rx_pkg::QUAL_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_one,
  input  logic line_zero,
  output logic stb,
  output logic ev_one,
  output logic ev_zero,
  output logic lvl_null,
  output logic bad
);
  localparam int HW = QUAL_LEN + 1;

  logic [HW-1:0] hist_one, hist_zero, hist_bad;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_one  <= '0;
      hist_zero <= '0;
      hist_bad  <= '0;
      stb_q     <= 1'b0;
    end else begin
      stb_q <= tick;
      if (tick) begin
        hist_one  <= {hist_one[HW-2:0],  line_one & ~line_zero};
        hist_zero <= {hist_zero[HW-2:0], line_zero & ~line_one};
        hist_bad  <= {hist_bad[HW-2:0],  line_one & line_zero};
      end
    end
  end

  // A level event fires on the sample that completes QUAL_LEN equal samples
  assign stb      = stb_q;
  assign ev_one   = stb_q & (&hist_one[QUAL_LEN-1:0])  & ~hist_one[QUAL_LEN];
  assign ev_zero  = stb_q & (&hist_zero[QUAL_LEN-1:0]) & ~hist_zero[QUAL_LEN];
  assign lvl_null = ~|(hist_one[QUAL_LEN-1:0] | hist_zero[QUAL_LEN-1:0] |
                       hist_bad[QUAL_LEN-1:0]);
  assign bad      = stb_q & hist_bad[0];

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(hist_one) && $stable(hist_zero))) else $error("hist moved without tick"); // R2
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_one && ev_zero)) else $error("one and zero qualified together"); // R5
endmodule

// File: rtl/a429_word_framer.sv
module a429_word_framer
  import a429_rx_pkg::*;
#(
  parameter int WORD_W     = a429_rx_pkg::WORD_W,
  parameter int BIT_MIN    = a429_rx_pkg::BIT_MIN,
  parameter int BIT_MAX    = a429_rx_pkg::BIT_MAX,
  parameter int GAP_PERIOD = a429_rx_pkg::GAP_PERIOD,
  parameter int GAP_NULLS  = a429_rx_pkg::GAP_NULLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              ev_one,
  input  logic              ev_zero,
  input  logic              lvl_null,
  input  logic              bad,
  output logic              word_stb,
  output logic [WORD_W-1:0] word
);
  localparam int SP_W = $clog2(BIT_MAX + 1);
  localparam int BC_W = $clog2(WORD_W);
  localparam int GT_W = $clog2(GAP_PERIOD);
  localparam int GC_W = $clog2(GAP_NULLS + 1);

  rx_state_e         st, st_n;
  logic [SP_W-1:0]   sp, sp_n, sp_inc;
  logic [BC_W-1:0]   bc, bc_n;
  logic [WORD_W-2:0] sr, sr_n;
  logic [GT_W-1:0]   gt, gt_n;
  logic [GC_W-1:0]   gc, gc_n;
  logic              stb_n, ev, go_gap;
  logic [WORD_W-1:0] word_n;

  assign sp_inc = sp + 1'b1;
  assign ev     = ev_one | ev_zero;

  always_comb begin
    st_n   = st;
    sp_n   = sp;
    bc_n   = bc;
    sr_n   = sr;
    gt_n   = gt;
    gc_n   = gc;
    stb_n  = 1'b0;
    word_n = word;
    go_gap = 1'b0;
    if (stb) begin
      if (bad) begin
        go_gap = 1'b1;
      end else begin
        case (st)
          ST_GAP: begin
            if (gt == GT_W'(GAP_PERIOD - 1)) begin
              gt_n = '0;
              if (lvl_null) begin
                if (gc == GC_W'(GAP_NULLS - 1)) begin
                  st_n = ST_IDLE;
                  gc_n = '0;
                end else begin
                  gc_n = gc + 1'b1;
                end
              end else begin
                gc_n = '0;
              end
            end else begin
              gt_n = gt + 1'b1;
            end
          end
          ST_IDLE: begin
            if (ev) begin
              st_n = ST_PULSE;
              sp_n = '0;
              bc_n = BC_W'(1);
              sr_n = {ev_one, sr[WORD_W-2:1]};
            end
          end
          ST_PULSE: begin
            if (ev || sp_inc >= SP_W'(BIT_MAX)) begin
              go_gap = 1'b1;
            end else begin
              sp_n = sp_inc;
              if (lvl_null) st_n = ST_NULLS;
            end
          end
          default: begin
            if (ev) begin
              if (sp_inc >= SP_W'(BIT_MIN) && sp_inc <= SP_W'(BIT_MAX)) begin
                if (bc == BC_W'(WORD_W - 1)) begin
                  stb_n  = 1'b1;
                  word_n = {~((^sr) ^ ev_one), sr};
                  st_n   = ST_GAP;
                  gt_n   = '0;
                  gc_n   = '0;
                end else begin
                  sr_n = {ev_one, sr[WORD_W-2:1]};
                  bc_n = bc + 1'b1;
                  sp_n = '0;
                  st_n = ST_PULSE;
                end
              end else begin
                go_gap = 1'b1;
              end
            end else if (sp_inc >= SP_W'(BIT_MAX)) begin
              go_gap = 1'b1;
            end else begin
              sp_n = sp_inc;
            end
          end
        endcase
      end
      if (go_gap) begin
        st_n = ST_GAP;
        gt_n = '0;
        gc_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_GAP;
      sp       <= '0;
      bc       <= '0;
      sr       <= '0;
      gt       <= '0;
      gc       <= '0;
      word_stb <= 1'b0;
      word     <= '0;
    end else begin
      st       <= st_n;
      sp       <= sp_n;
      bc       <= bc_n;
      sr       <= sr_n;
      gt       <= gt_n;
      gc       <= gc_n;
      word_stb <= stb_n;
      word     <= word_n;
    end
  end

  AST_ILLEGAL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && bad) |=> (st == ST_GAP && !word_stb)) else $error("illegal sample kept word"); // R9
  AST_WORD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb) else $error("back-to-back words"); // R8
  AST_GAP_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |=> (st != ST_PULSE && st != ST_NULLS)) else $error("bit taken during gap"); // R8
endmodule

// File: rtl/a429_rx_decoder.sv
module a429_rx_decoder
  import a429_rx_pkg::*;
#(
  parameter int WORD_W = a429_rx_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_slow,
  input  logic              line_one,
  input  logic              line_zero,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic              tick, stb, ev_one, ev_zero, lvl_null, bad, word_stb;
  logic [WORD_W-1:0] word;

  a429_sample_tick u_tick (
    .clk(clk), .rst_n(rst_n), .speed_slow(speed_slow), .tick(tick)
  );

  a429_level_qual u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .line_one(line_one), .line_zero(line_zero),
    .stb(stb), .ev_one(ev_one), .ev_zero(ev_zero),
    .lvl_null(lvl_null), .bad(bad)
  );

  a429_word_framer #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ev_one(ev_one), .ev_zero(ev_zero),
    .lvl_null(lvl_null), .bad(bad), .word_stb(word_stb), .word(word)
  );

  // Output holding stage: a newer word replaces an unaccepted one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (word_stb) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid) else $error("valid dropped early"); // R10
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !word_stb) |=> $stable(out_data)) else $error("held data changed"); // R10
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !word_stb) |=> !out_valid) else $error("valid stuck after accept"); // R10
endmodule

// File: tb/test_a429_rx_decoder.sv
`timescale 1ns/1ps
module test_a429_rx_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        speed_slow = 1'b0;
  logic        line_one = 1'b0;
  logic        line_zero = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [31:0] out_data;

  int          n_chk = 0;
  int          n_fail = 0;
  int          hs_cnt = 0;
  logic [31:0] hs_data = '0;
  int          samp_clks = 1;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  a429_rx_decoder i_a429_rx_decoder (
    .clk(clk), .rst_n(rst_n), .speed_slow(speed_slow),
    .line_one(line_one), .line_zero(line_zero),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      hs_cnt  = hs_cnt + 1;
      hs_data = out_data;
    end
  end

  function automatic logic [31:0] expect_word(input logic [31:0] w);
    return {(^w) ? 1'b0 : 1'b1, w[30:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic o, input logic z, input int n);
    line_one  = o;
    line_zero = z;
    repeat (n * samp_clks) @(negedge clk);
  endtask

  // fault: 0 none, 1 illegal sample in null, 2 short pulse, 3 pulse with no null
  task automatic send_word(input logic [31:0] w, input int per, input int pw,
                           input int fault, input int fbit);
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = w[i];
      if (fault == 3 && i == fbit) begin
        put(b, !b, per);
      end else if (fault == 2 && i == fbit) begin
        put(b, !b, 2); put(1'b0, 1'b0, per - 2);
      end else if (fault == 1 && i == fbit) begin
        put(b, !b, pw); put(1'b0, 1'b0, 2); put(1'b1, 1'b1, 1);
        put(1'b0, 1'b0, per - pw - 3);
      end else begin
        put(b, !b, pw); put(1'b0, 1'b0, per - pw);
      end
    end
  endtask

  task automatic run_case(input string req, input logic [31:0] w, input int per,
                          input int fault, input int fbit, input bit ok);
    int c0;
    c0 = hs_cnt;
    send_word(w, per, per / 2, fault, fbit);
    put(1'b0, 1'b0, 70);
    chk(req, 32'(hs_cnt - c0), ok ? 32'd1 : 32'd0);
    if (ok) chk(req, hs_data, expect_word(w));
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 data in reset", out_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
    put(1'b0, 1'b0, 70);

    // R3 / R4: walking bits with mixed background
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = (32'h1 << i) ^ (32'(i) * 32'h9E37_79B9);
      run_case("R3 walking word", w, 10, 0, 0, 1'b1);
    end
    run_case("R4 odd parity flag", 32'h0000_0001, 10, 0, 0, 1'b1);
    run_case("R4 even parity flag", 32'h0000_0003, 10, 0, 0, 1'b1);
    run_case("R4 all ones", 32'hFFFF_FFFF, 10, 0, 0, 1'b1);

    // R7: sweep the bit period across and beyond the window
    for (int p = 6; p <= 14; p++) begin
      run_case("R7 bit spacing", 32'hA5C3_0F96 ^ 32'(p), p, 0, 0, (p >= 8 && p <= 12));
    end

    run_case("R5 two-sample pulse", 32'h1234_5678, 10, 2, 5, 1'b0);
    run_case("R6 pulse without null", 32'h0000_0020, 10, 3, 5, 1'b0);
    run_case("R9 illegal sample", 32'hCAFE_F00D, 10, 1, 9, 1'b0);
    run_case("R9 recovery", 32'h0BAD_BEEF, 10, 0, 0, 1'b1);

    // R8: second word starts too soon after the first
    c0 = hs_cnt;
    send_word(32'h1111_2222, 10, 5, 0, 0);
    put(1'b0, 1'b0, 10);
    send_word(32'h3333_4444, 10, 5, 0, 0);
    put(1'b0, 1'b0, 70);
    chk("R8 short gap count", 32'(hs_cnt - c0), 32'd1);
    chk("R8 short gap data", hs_data, expect_word(32'h1111_2222));

    // R10: back-pressure and overwrite
    @(posedge clk); #1 out_ready = 1'b0;
    c0 = hs_cnt;
    send_word(32'h5555_0001, 10, 5, 0, 0);
    put(1'b0, 1'b0, 70);
    chk("R10 valid held", 32'(out_valid), 32'd1);
    chk("R10 data held", out_data, expect_word(32'h5555_0001));
    send_word(32'h6666_0003, 10, 5, 0, 0);
    put(1'b0, 1'b0, 70);
    chk("R10 overwrite data", out_data, expect_word(32'h6666_0003));
    chk("R10 no accept while stalled", 32'(hs_cnt - c0), 32'd0);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 one accept", 32'(hs_cnt - c0), 32'd1);
    chk("R10 accepted data", hs_data, expect_word(32'h6666_0003));
    chk("R10 valid released", 32'(out_valid), 32'd0);

    // R2: slow sampling
    speed_slow = 1'b1;
    samp_clks  = 8;
    put(1'b0, 1'b0, 70);
    run_case("R2 slow word", 32'h7E81_4C2D, 10, 0, 0, 1'b1);
    c0 = hs_cnt;
    samp_clks = 1;
    send_word(32'h7E81_4C2D, 10, 5, 0, 0);
    samp_clks = 8;
    put(1'b0, 1'b0, 70);
    chk("R2 fast word in slow mode", 32'(hs_cnt - c0), 32'd0);
    speed_slow = 1'b0;
    samp_clks  = 1;
    put(1'b0, 1'b0, 70);
    run_case("R2 back to fast", 32'h0F0F_3C3C, 10, 0, 0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule